// File: doc/BRIEF.md
# Byte-Wide Flash Command Decoder

This block is a synthesizable model of the command front end of a byte-wide NOR flash. The chip-enable, write-enable and output-enable pins are asynchronous, so the block synchronises them to a system clock. It forms write bus cycles from them and steps a decoder through the multi-cycle unlock sequences for four operations: byte program, sector erase, chip erase and identification (autoselect) mode. A write of 0xF0 returns the decoder to plain read mode. The commands act on a byte array held inside the block.

The array is a scaled-down image of the part. It has 2^MEM_W bytes, split into sectors of 2^SECT_W bytes. Its BOOT_SECTS end sectors form a boot region that the `boot_lock` input can protect, and TOP_BOOT selects whether that region sits at the top or the bottom of the array. Program can only clear bits. Erase walks bytes one clock at a time and sets them to 0xFF, so an erase takes as many cycles as it has bytes. A byte program holds the part busy for PROG_CYC cycles. While the part is busy, reads return a status byte. After reset the whole array is erased, which matches a part shipped blank.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the block runs an erase of the whole array. Once it completes, every byte reads 0xFF, and a read in read mode returns the array byte at address bits [MEM_W-1:0].
- R2: `dout_en` is high only while the synchronised CE and OE are low and WE is high. It is low during reset and during a write.
- R3: A byte program takes four writes: 0x05555/0xAA, 0x02AAA/0x55, 0x05555/0xA0, then the target address with its data. After PROG_CYC cycles the byte holds the bitwise AND of its old value and the data.
- R4: A write whose full 17-bit address or data does not match the expected step returns the decoder to read mode and changes no byte.
- R5: A sector erase takes five writes: 0x05555/0xAA, 0x02AAA/0x55, 0x05555/0x80, 0x05555/0xAA, 0x02AAA/0x55. A sixth write of data 0x30 to any address in the sector follows. The erase sets every byte of that sector to 0xFF and leaves other sectors unchanged.
- R6: A chip erase uses the same five writes, followed by 0x05555/0x10. It sets every byte of the array to 0xFF, one sector after another.
- R7: While `boot_lock` is high, program and erase leave bytes in the boot sectors unchanged, and a chip erase skips those sectors. The boot sectors are the top BOOT_SECTS sectors when TOP_BOOT is 1.
- R8: While busy, reads return a status byte. Bit 7 is the complement of bit 7 of the target data (0 during erase). Bit 6 flips after every completed read. Bits 5:0 are 0.
- R9: Writes made while busy are ignored, including a complete program sequence.
- R10: Autoselect mode is entered with 0x05555/0xAA, 0x02AAA/0x55, 0x05555/0x90. In this mode, a read with address bits [1:0] = 00 returns 0x40. Bits 01 return 0x01 (top variant) or 0xA1 (bottom variant). Bits 10 return 0x01 when the boot region is locked and 0x00 when it is not. Writes other than data 0xF0 are ignored in this mode.
- R11: A bus cycle with OE low is not a write cycle and does not advance the decoder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; starts the power-on erase |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| boot_lock | input | 1 | High protects the boot sectors |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data, sampled at the end of the write cycle |
| dout | output | 8 | Read data: array byte, status byte or identification code |
| dout_en | output | 1 | High when `dout` should drive the data bus |

## Verification
Most internal faults in this block show up only on a later read. A decoder step that goes wrong surfaces after the read that follows the expected busy window, either as an unchanged byte or as a byte changed when it should not be. A wrong lock or sector range appears as a byte in a neighbouring or boot sector that differs from its known value. The status byte gives earlier visibility: a broken busy state is visible within the first read after a command's last write, as a missing complemented bit 7 or a bit 6 that stops flipping.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W     = 17,
  parameter int MEM_W      = 11,
  parameter int SECT_W     = 7,
  parameter int BOOT_SECTS = 2,
  parameter bit TOP_BOOT   = 1'b1,
  parameter int PROG_CYC   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              boot_lock,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);
  localparam int SW    = MEM_W - SECT_W;
  localparam int NSECT = 1 << SW;
  localparam int CW    = $clog2(PROG_CYC + 1);
  localparam logic [SW-1:0] TOP_FIRST = SW'(NSECT - BOOT_SECTS);
  localparam logic [SW-1:0] BOT_LIMIT = SW'(BOOT_SECTS);
  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(17'h05555);
  localparam logic [ADDR_W-1:0] KEY_B = ADDR_W'(17'h02AAA);
  localparam logic [7:0] DEV_ID = TOP_BOOT ? 8'h01 : 8'hA1;

  typedef enum logic [3:0] {
    S_READ, S_U1, S_U2, S_PGM, S_E1, S_E2, S_E3, S_AUTO, S_PBUSY, S_EBUSY
  } st_t;

  function automatic logic in_boot(input logic [MEM_W-1:0] a);
    logic [SW-1:0] s;
    s = a[MEM_W-1:SECT_W];
    return TOP_BOOT ? (s >= TOP_FIRST) : (s < BOT_LIMIT);
  endfunction

  st_t st;
  logic [1:0] ce_s, we_s, oe_s;
  logic wr_q, rd_q, tog, init_q;
  logic [ADDR_W-1:0] a_q;
  logic [7:0] pd_q;
  logic [MEM_W-1:0] ptr, last;
  logic [CW-1:0] cnt;
  logic [7:0] mem [0:(1<<MEM_W)-1];

  wire wr_act  = ~ce_s[1] & ~we_s[1] & oe_s[1];
  wire rd_act  = ~ce_s[1] & ~oe_s[1] & we_s[1];
  wire wr_rise = wr_act & ~wr_q;
  wire wr_fall = ~wr_act & wr_q;
  wire rd_fall = ~rd_act & rd_q;
  wire busy    = (st == S_PBUSY) || (st == S_EBUSY);
  wire k5      = (a_q == KEY_A);
  wire k2      = (a_q == KEY_B);

  wire prot_pgm = boot_lock & in_boot(a_q[MEM_W-1:0]);
  wire prot_ers = boot_lock & in_boot(ptr) & ~init_q;

  logic             mem_we;
  logic [MEM_W-1:0] mem_wa;
  logic [7:0]       mem_wd;

  always_comb begin
    mem_we = 1'b0;
    mem_wa = a_q[MEM_W-1:0];
    mem_wd = mem[a_q[MEM_W-1:0]] & pd_q;
    if (st == S_PBUSY) begin
      mem_we = (cnt == '0) && !prot_pgm;
    end else if (st == S_EBUSY) begin
      mem_we = !prot_ers;
      mem_wa = ptr;
      mem_wd = 8'hFF;
    end
  end

  always_ff @(posedge clk)
    if (mem_we) mem[mem_wa] <= mem_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_EBUSY;
      init_q <= 1'b1;
      ce_s <= 2'b11; we_s <= 2'b11; oe_s <= 2'b11;
      wr_q <= 1'b0; rd_q <= 1'b0; tog <= 1'b0;
      a_q <= '0; pd_q <= 8'hFF;
      ptr <= '0; last <= '1; cnt <= '0;
    end else begin
      ce_s <= {ce_s[0], ce_n};
      we_s <= {we_s[0], we_n};
      oe_s <= {oe_s[0], oe_n};
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_rise && !busy) a_q <= addr;
      if (rd_fall && busy) tog <= ~tog;
      case (st)
        S_PBUSY: if (cnt == '0) st <= S_READ; else cnt <= cnt - 1'b1;
        S_EBUSY: if (ptr == last) begin st <= S_READ; init_q <= 1'b0; end
                 else ptr <= ptr + 1'b1;
        default: if (wr_fall) begin
          if (st == S_PGM) begin
            pd_q <= din; cnt <= CW'(PROG_CYC - 1); st <= S_PBUSY;
          end else if (din == 8'hF0) begin
            st <= S_READ;
          end else begin
            case (st)
              S_READ: st <= (k5 && din == 8'hAA) ? S_U1 : S_READ;
              S_AUTO: st <= S_AUTO;
              S_U1:   st <= (k2 && din == 8'h55) ? S_U2 : S_READ;
              S_U2:   if (k5 && din == 8'hA0) st <= S_PGM;
                      else if (k5 && din == 8'h80) st <= S_E1;
                      else if (k5 && din == 8'h90) st <= S_AUTO;
                      else st <= S_READ;
              S_E1:   st <= (k5 && din == 8'hAA) ? S_E2 : S_READ;
              S_E2:   st <= (k2 && din == 8'h55) ? S_E3 : S_READ;
              S_E3:   if (k5 && din == 8'h10) begin
                        ptr <= '0; last <= '1; pd_q <= 8'hFF; st <= S_EBUSY;
                      end else if (din == 8'h30) begin
                        ptr  <= {a_q[MEM_W-1:SECT_W], {SECT_W{1'b0}}};
                        last <= {a_q[MEM_W-1:SECT_W], {SECT_W{1'b1}}};
                        pd_q <= 8'hFF; st <= S_EBUSY;
                      end else st <= S_READ;
              default: st <= S_READ;
            endcase
          end
        end
      endcase
    end
  end

  always_comb begin
    if (busy)
      dout = {~pd_q[7], tog, 6'b0};
    else if (st == S_AUTO)
      case (addr[1:0])
        2'b00:   dout = 8'h40;
        2'b01:   dout = DEV_ID;
        2'b10:   dout = {7'b0, boot_lock};
        default: dout = 8'h00;
      endcase
    else
      dout = mem[addr[MEM_W-1:0]];
  end

  assign dout_en = rd_act;

  // R2: outputs stay off while CE has been high long enough to pass the synchroniser
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ce_n) && $past(ce_n, 2) && $past(ce_n, 3)) |-> !dout_en);

  // R3: a program write never sets a bit that was clear
  p_pgm_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PBUSY && mem_we) |-> ((mem_wd & ~mem[mem_wa]) == 8'h00));

  // R5: erase writes only ones
  p_erase_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EBUSY && mem_we) |-> (mem_wd == 8'hFF));

  // R7: no write lands in a locked boot sector after the power-on erase
  p_boot_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !init_q) |-> !(boot_lock && in_boot(mem_wa)));

  // R9: captured target stays fixed through a busy period
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(a_q) && $stable(pd_q)));
endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, boot_lock = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en;
  int applied = 0, bad = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder u0 (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .boot_lock(boot_lock), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en));

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  rq;
    logic [16:0] a;
    logic [7:0]  d;
    logic [7:0]  e;
  } vec_t;
  localparam logic [1:0] OW = 2'd0, ORD = 2'd1, ODL = 2'd2;
  localparam int NV = 48;
  localparam vec_t TAB [NV] = '{
    '{ORD,4'd1,17'h00123,8'h00,8'hFF},  // R1 blank after init
    '{ORD,4'd1,17'h007FF,8'h00,8'hFF},  // R1
    '{OW, 4'd3,17'h05555,8'hAA,8'h00},  // R3 program 5A
    '{OW, 4'd3,17'h02AAA,8'h55,8'h00},
    '{OW, 4'd3,17'h05555,8'hA0,8'h00},
    '{OW, 4'd3,17'h00123,8'h5A,8'h00},
    '{ODL,4'd3,17'd60,   8'h00,8'h00},
    '{ORD,4'd3,17'h00123,8'h00,8'h5A},
    '{OW, 4'd3,17'h05555,8'hAA,8'h00},  // R3 program 0F -> AND gives 0A
    '{OW, 4'd3,17'h02AAA,8'h55,8'h00},
    '{OW, 4'd3,17'h05555,8'hA0,8'h00},
    '{OW, 4'd3,17'h00123,8'h0F,8'h00},
    '{ODL,4'd3,17'd60,   8'h00,8'h00},
    '{ORD,4'd3,17'h00123,8'h00,8'h0A},
    '{OW, 4'd4,17'h05555,8'hAA,8'h00},  // R4 wrong data in step two
    '{OW, 4'd4,17'h02AAA,8'h56,8'h00},
    '{OW, 4'd4,17'h05555,8'hA0,8'h00},
    '{OW, 4'd4,17'h00123,8'h00,8'h00},
    '{ODL,4'd4,17'd60,   8'h00,8'h00},
    '{ORD,4'd4,17'h00123,8'h00,8'h0A},
    '{OW, 4'd4,17'h05555,8'hAA,8'h00},  // R4 wrong address in step three
    '{OW, 4'd4,17'h02AAA,8'h55,8'h00},
    '{OW, 4'd4,17'h15555,8'hA0,8'h00},
    '{OW, 4'd4,17'h00123,8'h00,8'h00},
    '{ODL,4'd4,17'd60,   8'h00,8'h00},
    '{ORD,4'd4,17'h00123,8'h00,8'h0A},
    '{OW, 4'd5,17'h05555,8'hAA,8'h00},  // R5 program neighbour sector
    '{OW, 4'd5,17'h02AAA,8'h55,8'h00},
    '{OW, 4'd5,17'h05555,8'hA0,8'h00},
    '{OW, 4'd5,17'h00200,8'h33,8'h00},
    '{ODL,4'd5,17'd60,   8'h00,8'h00},
    '{OW, 4'd5,17'h05555,8'hAA,8'h00},  // R5 erase sector holding 0x123
    '{OW, 4'd5,17'h02AAA,8'h55,8'h00},
    '{OW, 4'd5,17'h05555,8'h80,8'h00},
    '{OW, 4'd5,17'h05555,8'hAA,8'h00},
    '{OW, 4'd5,17'h02AAA,8'h55,8'h00},
    '{OW, 4'd5,17'h00150,8'h30,8'h00},
    '{ODL,4'd5,17'd200,  8'h00,8'h00},
    '{ORD,4'd5,17'h00123,8'h00,8'hFF},
    '{ORD,4'd5,17'h00200,8'h00,8'h33},
    '{OW,4'd10,17'h05555,8'hAA,8'h00},  // R10 autoselect
    '{OW,4'd10,17'h02AAA,8'h55,8'h00},
    '{OW,4'd10,17'h05555,8'h90,8'h00},
    '{ORD,4'd10,17'h00000,8'h00,8'h40},
    '{ORD,4'd10,17'h00001,8'h00,8'h01},
    '{ORD,4'd10,17'h00002,8'h00,8'h00},
    '{OW,4'd10,17'h00000,8'hF0,8'h00},
    '{ORD,4'd10,17'h00200,8'h00,8'h33}
  };

  task automatic check(input int rq, input logic [7:0] got, input logic [7:0] exp);
    applied++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d: got %h expected %h", rq, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [16:0] a, input logic [7:0] d, input bit oe_low = 1'b0);
    @(negedge clk);
    addr = a; din = d; oe_n = oe_low ? 1'b0 : 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [16:0] a, output logic [7:0] d, output logic en);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (4) @(negedge clk);
    d = dout; en = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic prog(input logic [16:0] a, input logic [7:0] d);
    bus_wr(17'h05555, 8'hAA); bus_wr(17'h02AAA, 8'h55);
    bus_wr(17'h05555, 8'hA0); bus_wr(a, d);
  endtask

  task automatic erase_pre();
    bus_wr(17'h05555, 8'hAA); bus_wr(17'h02AAA, 8'h55); bus_wr(17'h05555, 8'h80);
    bus_wr(17'h05555, 8'hAA); bus_wr(17'h02AAA, 8'h55);
  endtask

  task automatic rd_check(input int rq, input logic [16:0] a, input logic [7:0] exp);
    logic [7:0] d; logic en;
    bus_rd(a, d, en);
    check(rq, d, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    logic [7:0] d1, d2; logic en;
    repeat (5) @(negedge clk);
    check(2, {7'b0, dout_en}, 8'h00);               // R2 quiet in reset
    rst_n = 1'b1;
    bus_rd(17'h00000, d1, en);
    check(8, {7'b0, en}, 8'h01);                    // R8 status readable during init erase
    check(8, d1 & 8'hBF, 8'h00);                    // R8 erase status bits
    repeat (2200) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (TAB[i].op)
        OW:  bus_wr(TAB[i].a, TAB[i].d);
        ORD: rd_check(int'(TAB[i].rq), TAB[i].a, TAB[i].e);
        default: repeat (int'(TAB[i].a)) @(negedge clk);
      endcase
    end

    // R2: no drive while WE is low
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    repeat (4) @(negedge clk);
    check(2, {7'b0, dout_en}, 8'h00);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: first unlock cycle with OE low does not count
    bus_wr(17'h05555, 8'hAA, 1'b1); bus_wr(17'h02AAA, 8'h55);
    bus_wr(17'h05555, 8'hA0); bus_wr(17'h00600, 8'h00);
    repeat (60) @(negedge clk);
    rd_check(11, 17'h00600, 8'hFF);

    // R8: program status, bit 7 complemented, bit 6 flips per read
    prog(17'h00300, 8'h25);
    bus_rd(17'h00300, d1, en);
    bus_rd(17'h00300, d2, en);
    check(8, d1 & 8'hBF, 8'h80);
    check(8, {7'b0, d1[6] ^ d2[6]}, 8'h01);
    repeat (60) @(negedge clk);
    rd_check(3, 17'h00300, 8'h25);

    // R9: program sequence during a sector erase is ignored
    erase_pre(); bus_wr(17'h00400, 8'h30);
    prog(17'h00500, 8'h00);
    bus_rd(17'h00400, d1, en);
    check(8, d1 & 8'hBF, 8'h00);
    repeat (200) @(negedge clk);
    rd_check(9, 17'h00500, 8'hFF);

    // R7: boot region lock
    prog(17'h007F0, 8'h22);
    repeat (60) @(negedge clk);
    boot_lock = 1'b1;
    prog(17'h007F0, 8'h00);
    repeat (60) @(negedge clk);
    rd_check(7, 17'h007F0, 8'h22);
    erase_pre(); bus_wr(17'h00780, 8'h30);
    repeat (200) @(negedge clk);
    rd_check(7, 17'h007F0, 8'h22);
    bus_wr(17'h05555, 8'hAA); bus_wr(17'h02AAA, 8'h55); bus_wr(17'h05555, 8'h90);
    rd_check(10, 17'h00002, 8'h01);                 // R10 lock status
    bus_wr(17'h01234, 8'hAA);
    rd_check(10, 17'h00001, 8'h01);                 // R10 stays in autoselect
    bus_wr(17'h00000, 8'hF0);

    // R6: chip erase, boot region kept while locked
    erase_pre(); bus_wr(17'h05555, 8'h10);
    repeat (2200) @(negedge clk);
    rd_check(6, 17'h00200, 8'hFF);
    rd_check(6, 17'h00300, 8'hFF);
    rd_check(7, 17'h007F0, 8'h22);

    boot_lock = 1'b0;
    erase_pre(); bus_wr(17'h007F0, 8'h30);
    repeat (200) @(negedge clk);
    rd_check(7, 17'h007F0, 8'hFF);

    $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule